// File: doc/BRIEF.md
# Register-List Block Transfer Sequencer

This block turns one multi-register transfer command into a series of single-word memory requests. A command names an operation, an 8-bit register list, a start address and an optional extra register. The block walks the list, issues one 32-bit request per cycle on a valid/ready memory port, reads store data from a small low-register file through an asynchronous read port, and writes loaded words back to that file through a registered write port.

Four operations exist. Two are increment-after block transfers based on a chosen low register. Two are stack operations on the stack pointer: a push that may also save the return-link value, and a pop that may also end by loading the program counter. When the walk ends the block raises a one-cycle completion pulse together with the value that the base register or stack pointer should take. The surrounding core applies that value when the valid flag is set.

Top module: `reglist_xfer_seq`

## Requirements
- R1: After reset, cmd_ready is 1, and mem_req, done, rf_we, pc_we and wb_valid are all 0.
- R2: With cmd_op 0 (block load) or 1 (block store), requests start at cmd_base. One request is made for each set list bit, in ascending register order, and the address rises by 4 after each one. A load writes the word it reads to that register. A store sends that register's value with mem_we set.
- R3: At completion of a block store, wb_valid is 1. At completion of a block load, wb_valid is 1 only when list bit cmd_rn is clear. In both cases wb_value is cmd_base plus 4 times the number of transfers, wb_sp is 0 and wb_rn equals cmd_rn.
- R4: With cmd_op 2 (push), the first request is made at cmd_base minus 4. When cmd_extra is 1, that first word is cmd_lr. The listed registers follow from 7 down to 0, and the address falls by 4 after each store.
- R5: At completion of a push, wb_valid and wb_sp are 1. wb_value is the lowest address written, which is cmd_base minus 4 times the number of transfers.
- R6: With cmd_op 3 (pop), loads start at cmd_base and go in ascending register order, the address rising by 4 each time. When cmd_extra is 1, one last load goes to the program counter: pc_we pulses with bit 0 of the loaded word cleared. wb_valid and wb_sp are 1, and wb_value is cmd_base plus 4 times the number of transfers.
- R7: cmd_extra has no effect on block loads and stores.
- R8: A command with an empty list and no extra register makes no memory request. done rises in the cycle after acceptance, and wb_value equals cmd_base.
- R9: done is high for exactly one cycle: the cycle after the last accepted memory request.
- R10: cmd_ready is high only while idle. A command presented while busy is ignored.
- R11: While mem_ready is low, a pending request keeps mem_req, mem_addr and mem_we unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command taken |
| cmd_op | input | 2 | 0 load, 1 store, 2 push, 3 pop |
| cmd_list | input | 8 | Register list |
| cmd_rn | input | 3 | Base register index (block load/store) |
| cmd_extra | input | 1 | Include link (push) or program counter (pop) |
| cmd_base | input | 32 | Base register value or stack pointer |
| cmd_lr | input | 32 | Link value stored by push |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Store data |
| mem_ready | input | 1 | Memory accepts request this cycle |
| mem_rdata | input | 32 | Load data, valid with mem_ready |
| rf_raddr | output | 3 | Register file read index |
| rf_rdata | input | 32 | Register file read data |
| rf_we | output | 1 | Register file write strobe |
| rf_waddr | output | 3 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| pc_we | output | 1 | Program counter load strobe |
| pc_value | output | 32 | Loaded program counter, bit 0 clear |
| done | output | 1 | Completion pulse |
| wb_valid | output | 1 | Writeback of base/stack pointer required |
| wb_sp | output | 1 | Writeback target is the stack pointer |
| wb_rn | output | 3 | Writeback target low register |
| wb_value | output | 32 | Final base or stack pointer value |

## Verification
Each operation is run with sparse lists, a full list and a single high register, so that the order of the walk and the direction of the address step can be seen. Block loads run once with the base register outside the list and once inside it, which shows whether writeback is suppressed. Pushes with and without the link value are later undone by pops from the resulting stack pointer; these pops show the ordering, whether the link value lands in the lowest or highest word, and the clearing of bit 0 on the program-counter load. Empty lists, lists holding only the extra register, and stalls on the memory port separate the completion timing from the number of transfers.

// File: rtl/reglist_xfer_pkg.sv
package reglist_xfer_pkg;
  typedef enum logic [1:0] {
    OP_LDM  = 2'd0,
    OP_STM  = 2'd1,
    OP_PUSH = 2'd2,
    OP_POP  = 2'd3
  } blk_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MOVE = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/reglist_pick.sv
// Priority picker over a register mask: lowest or highest set bit.
module reglist_pick #(
  parameter int NREG      = 8,
  parameter bit LOW_FIRST = 1'b1,
  parameter int IW        = $clog2(NREG)
) (
  input  logic [NREG-1:0] mask,
  output logic [IW-1:0]   idx,
  output logic            any
);
  assign any = |mask;

  generate
    if (LOW_FIRST) begin : g_low
      always_comb begin
        idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
          if (mask[i]) idx = IW'(i);
        end
      end
    end else begin : g_high
      always_comb begin
        idx = '0;
        for (int i = 0; i < NREG; i++) begin
          if (mask[i]) idx = IW'(i);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/reglist_xfer_seq.sv
module reglist_xfer_seq
  import reglist_xfer_pkg::*;
#(
  parameter int NREG = 8,
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int STEP = 4,
  parameter int IW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [1:0]      cmd_op,
  input  logic [NREG-1:0] cmd_list,
  input  logic [IW-1:0]   cmd_rn,
  input  logic            cmd_extra,
  input  logic [AW-1:0]   cmd_base,
  input  logic [DW-1:0]   cmd_lr,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_ready,
  input  logic [DW-1:0]   mem_rdata,
  output logic [IW-1:0]   rf_raddr,
  input  logic [DW-1:0]   rf_rdata,
  output logic            rf_we,
  output logic [IW-1:0]   rf_waddr,
  output logic [DW-1:0]   rf_wdata,
  output logic            pc_we,
  output logic [AW-1:0]   pc_value,
  output logic            done,
  output logic            wb_valid,
  output logic            wb_sp,
  output logic [IW-1:0]   wb_rn,
  output logic [AW-1:0]   wb_value
);
  localparam logic [AW-1:0] STEP_A = AW'(STEP);

  seq_state_e      st_q;
  blk_op_e         op_q;
  logic [NREG-1:0] list_q, left_q, left_nxt;
  logic            xtra_q, xtra_nxt;
  logic [IW-1:0]   rn_q;
  logic [AW-1:0]   addr_q, addr_nxt;
  logic [DW-1:0]   lr_q;

  logic            rf_we_q, pc_we_q;
  logic [IW-1:0]   rf_waddr_q;
  logic [DW-1:0]   rf_wdata_q;
  logic [AW-1:0]   pc_q;

  logic [IW-1:0]   lo_idx, hi_idx, cur_idx;
  logic            lo_any, hi_any;
  logic            is_push, is_load, cur_xtra, hs;
  logic            cmd_xtra_ok, cmd_nonempty;

  reglist_pick #(.NREG(NREG), .LOW_FIRST(1'b1), .IW(IW)) u_pick_lo (
    .mask(left_q), .idx(lo_idx), .any(lo_any)
  );
  reglist_pick #(.NREG(NREG), .LOW_FIRST(1'b0), .IW(IW)) u_pick_hi (
    .mask(left_q), .idx(hi_idx), .any(hi_any)
  );

  assign is_push  = (op_q == OP_PUSH);
  assign is_load  = (op_q == OP_LDM) || (op_q == OP_POP);
  assign cur_idx  = is_push ? hi_idx : lo_idx;
  // push handles the link word first, pop handles the PC word last
  assign cur_xtra = xtra_q && (is_push || !lo_any);
  assign hs       = (st_q == ST_MOVE) && mem_ready;
  assign addr_nxt = is_push ? (addr_q - STEP_A) : (addr_q + STEP_A);

  always_comb begin
    left_nxt = left_q;
    if (!cur_xtra) left_nxt[cur_idx] = 1'b0;
  end
  assign xtra_nxt = xtra_q && !cur_xtra;

  assign cmd_xtra_ok  = cmd_extra && cmd_op[1];
  assign cmd_nonempty = (|cmd_list) || cmd_xtra_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_LDM;
      list_q  <= '0;
      left_q  <= '0;
      xtra_q  <= 1'b0;
      rn_q    <= '0;
      addr_q  <= '0;
      lr_q    <= '0;
      rf_we_q <= 1'b0;
      pc_we_q <= 1'b0;
    end else begin
      rf_we_q <= hs && is_load && !cur_xtra;
      pc_we_q <= hs && is_load && cur_xtra;
      case (st_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            op_q   <= blk_op_e'(cmd_op);
            list_q <= cmd_list;
            left_q <= cmd_list;
            xtra_q <= cmd_xtra_ok;
            rn_q   <= cmd_rn;
            lr_q   <= cmd_lr;
            addr_q <= (blk_op_e'(cmd_op) == OP_PUSH) ? (cmd_base - STEP_A) : cmd_base;
            st_q   <= cmd_nonempty ? ST_MOVE : ST_DONE;
          end
        end
        ST_MOVE: begin
          if (hs) begin
            left_q <= left_nxt;
            xtra_q <= xtra_nxt;
            addr_q <= addr_nxt;
            if (!(|left_nxt) && !xtra_nxt) st_q <= ST_DONE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    rf_waddr_q <= cur_idx;
    rf_wdata_q <= mem_rdata;
    pc_q       <= AW'(mem_rdata) & ~AW'(1);
  end

  assign cmd_ready = (st_q == ST_IDLE);
  assign mem_req   = (st_q == ST_MOVE);
  assign mem_we    = !is_load;
  assign mem_addr  = addr_q;
  assign mem_wdata = cur_xtra ? lr_q : rf_rdata;
  assign rf_raddr  = cur_idx;
  assign rf_we     = rf_we_q;
  assign rf_waddr  = rf_waddr_q;
  assign rf_wdata  = rf_wdata_q;
  assign pc_we     = pc_we_q;
  assign pc_value  = pc_q;
  assign done      = (st_q == ST_DONE);
  assign wb_sp     = op_q[1];
  assign wb_rn     = rn_q;
  assign wb_value  = is_push ? (addr_q + STEP_A) : addr_q;
  assign wb_valid  = done && !((op_q == OP_LDM) && list_q[rn_q]);
endmodule

// File: rtl/reglist_xfer_chk.sv
module reglist_xfer_chk #(
  parameter int NREG = 8,
  parameter int AW   = 32,
  parameter int STEP = 4,
  parameter int IW   = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [1:0]      cmd_op,
  input logic [NREG-1:0] cmd_list,
  input logic [IW-1:0]   cmd_rn,
  input logic            cmd_extra,
  input logic            mem_req,
  input logic            mem_we,
  input logic [AW-1:0]   mem_addr,
  input logic            mem_ready,
  input logic            rf_we,
  input logic            pc_we,
  input logic [AW-1:0]   pc_value,
  input logic            done,
  input logic            wb_valid
);
  logic [1:0]      op_c;
  logic [NREG-1:0] list_c;
  logic [IW-1:0]   rn_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_c   <= '0;
      list_c <= '0;
      rn_c   <= '0;
    end else if (cmd_valid && cmd_ready) begin
      op_c   <= cmd_op;
      list_c <= cmd_list;
      rn_c   <= cmd_rn;
    end
  end

  assert_busy_R10: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !cmd_ready);

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  assert_step_up_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ready && (op_c != 2'd2) |=> !mem_req || (mem_addr == $past(mem_addr) + AW'(STEP)));

  assert_step_down_R4: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ready && (op_c == 2'd2) |=> !mem_req || (mem_addr == $past(mem_addr) - AW'(STEP)));

  assert_pc_even_R6: assert property (@(posedge clk) disable iff (rst)
    pc_we |-> !pc_value[0]);

  assert_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_empty_R8: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready && (cmd_list == '0) && !(cmd_extra && cmd_op[1]) |=> done && !mem_req);

  assert_ld_nowb_R3: assert property (@(posedge clk) disable iff (rst)
    done && (op_c == 2'd0) && list_c[rn_c] |-> !wb_valid);

  assert_one_wr_R6: assert property (@(posedge clk) disable iff (rst)
    !(rf_we && pc_we));
endmodule

bind reglist_xfer_seq reglist_xfer_chk #(.NREG(NREG), .AW(AW), .STEP(STEP), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_list(cmd_list), .cmd_rn(cmd_rn), .cmd_extra(cmd_extra),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ready(mem_ready),
  .rf_we(rf_we), .pc_we(pc_we), .pc_value(pc_value), .done(done), .wb_valid(wb_valid)
);

// File: tb/test_reglist_xfer_seq.sv
module test_reglist_xfer_seq;
  localparam logic [31:0] LR_VAL = 32'h0000_1235;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  list;
    logic [2:0]  rn;
    logic        xt;
    logic [31:0] base;
    logic [3:0]  cnt;
    logic [31:0] wb;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 8'h05, 3'd1, 1'b0, 32'h40, 4'd2, 32'h48},
    '{2'd0, 8'h06, 3'd2, 1'b0, 32'h60, 4'd2, 32'h68},
    '{2'd1, 8'hFF, 3'd0, 1'b0, 32'h80, 4'd8, 32'hA0},
    '{2'd1, 8'h80, 3'd3, 1'b1, 32'h10, 4'd1, 32'h14},
    '{2'd2, 8'h0B, 3'd0, 1'b0, 32'hC0, 4'd3, 32'hB4},
    '{2'd2, 8'h11, 3'd0, 1'b1, 32'hF0, 4'd3, 32'hE4},
    '{2'd3, 8'h0B, 3'd0, 1'b0, 32'hB4, 4'd3, 32'hC0},
    '{2'd3, 8'h11, 3'd0, 1'b1, 32'hE4, 4'd3, 32'hF0},
    '{2'd0, 8'h00, 3'd5, 1'b0, 32'h30, 4'd0, 32'h30},
    '{2'd2, 8'h00, 3'd0, 1'b0, 32'hC0, 4'd0, 32'hC0},
    '{2'd3, 8'h00, 3'd0, 1'b1, 32'h50, 4'd1, 32'h54},
    '{2'd2, 8'h00, 3'd0, 1'b1, 32'h40, 4'd1, 32'h3C}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid, cmd_ready, cmd_extra;
  logic [1:0]  cmd_op;
  logic [7:0]  cmd_list;
  logic [2:0]  cmd_rn;
  logic [31:0] cmd_base, cmd_lr;
  logic        mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [2:0]  rf_raddr, rf_waddr, wb_rn;
  logic [31:0] rf_rdata, rf_wdata, pc_value, wb_value;
  logic        rf_we, pc_we, done, wb_valid, wb_sp;

  always #4 clk = ~clk;

  reglist_xfer_seq i_reglist_xfer_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_list(cmd_list), .cmd_rn(cmd_rn), .cmd_extra(cmd_extra),
    .cmd_base(cmd_base), .cmd_lr(cmd_lr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .pc_we(pc_we), .pc_value(pc_value),
    .done(done), .wb_valid(wb_valid), .wb_sp(wb_sp), .wb_rn(wb_rn), .wb_value(wb_value)
  );

  logic [31:0] mem_m [0:63];
  logic [31:0] rf_m  [0:7];
  int unsigned cyc = 0;

  assign rf_rdata  = rf_m[rf_raddr];
  assign mem_rdata = mem_m[mem_addr[7:2]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      for (int i = 0; i < 64; i++) mem_m[i] <= 32'hA000_0001 | (32'(i) << 4);
      for (int i = 0; i < 8; i++)  rf_m[i]  <= 32'h1000_0000 + 32'(i) * 32'h111;
    end else begin
      if (rf_we) rf_m[rf_waddr] <= rf_wdata;
      if (mem_req && mem_ready && mem_we) mem_m[mem_addr[7:2]] <= mem_wdata;
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s got %h expected %h", req, what, act, exp);
    end
  endtask

  // expected transfer sequence
  logic [31:0] e_addr [0:8];
  logic [31:0] e_data [0:8];
  logic        e_we   [0:8];
  string       cur_tag = "R2";
  int          got_k = 0;
  int unsigned last_hs = 0;
  bit          stall = 1'b0, hold = 1'b0, pc_seen = 1'b0;
  logic [31:0] pc_got;
  int          wd = 0;
  logic        rdy;

  always @(negedge clk) begin
    rdy = !hold && !(stall && (cyc[1:0] == 2'b01));
    if (mem_req && rdy) begin
      if (got_k < 9) begin
        chk(mem_addr == e_addr[got_k], cur_tag, "request address", mem_addr, e_addr[got_k]);
        chk(mem_we == e_we[got_k], cur_tag, "request direction", 32'(mem_we), 32'(e_we[got_k]));
        if (e_we[got_k])
          chk(mem_wdata == e_data[got_k], cur_tag, "store data", mem_wdata, e_data[got_k]);
      end else begin
        chk(1'b0, cur_tag, "extra request", mem_addr, 32'h0);
      end
      got_k++;
      last_hs = cyc;
    end
    mem_ready = rdy;
    if (pc_we) begin
      pc_seen = 1'b1;
      pc_got  = pc_value;
    end
    wd++;
    if (wd > 50000) begin
      chk(1'b0, "watchdog", "cycles", 32'(wd), 32'd50000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic run_cmd(input vec_t v, input bit probe);
    logic [31:0] a, exp_pc, x_wb;
    logic [31:0] rf_exp [0:7];
    bit          exp_wv, exp_sp;
    int          n;
    int unsigned t_acc;
    for (int i = 0; i < 8; i++) rf_exp[i] = rf_m[i];
    n = 0;
    exp_pc = 32'h0;
    case (v.op)
      2'd0, 2'd1: begin
        cur_tag = "R2";
        a = v.base;
        for (int i = 0; i < 8; i++) if (v.list[i]) begin
          e_addr[n] = a; e_we[n] = (v.op == 2'd1); e_data[n] = rf_m[i];
          if (v.op == 2'd0) rf_exp[i] = mem_m[a[7:2]];
          n++; a = a + 4;
        end
        x_wb = a; exp_wv = (v.op == 2'd1) || !v.list[v.rn]; exp_sp = 1'b0;
      end
      2'd2: begin
        cur_tag = "R4";
        a = v.base - 4;
        if (v.xt) begin
          e_addr[n] = a; e_we[n] = 1'b1; e_data[n] = LR_VAL; n++; a = a - 4;
        end
        for (int i = 7; i >= 0; i--) if (v.list[i]) begin
          e_addr[n] = a; e_we[n] = 1'b1; e_data[n] = rf_m[i]; n++; a = a - 4;
        end
        x_wb = a + 4; exp_wv = 1'b1; exp_sp = 1'b1;
      end
      default: begin
        cur_tag = "R6";
        a = v.base;
        for (int i = 0; i < 8; i++) if (v.list[i]) begin
          e_addr[n] = a; e_we[n] = 1'b0; e_data[n] = 32'h0;
          rf_exp[i] = mem_m[a[7:2]]; n++; a = a + 4;
        end
        if (v.xt) begin
          e_addr[n] = a; e_we[n] = 1'b0; e_data[n] = 32'h0;
          exp_pc = mem_m[a[7:2]] & ~32'h1; n++; a = a + 4;
        end
        x_wb = a; exp_wv = 1'b1; exp_sp = 1'b1;
      end
    endcase
    got_k = 0;
    pc_seen = 1'b0;
    @(negedge clk);
    cmd_op = v.op; cmd_list = v.list; cmd_rn = v.rn; cmd_extra = v.xt;
    cmd_base = v.base; cmd_lr = LR_VAL; cmd_valid = 1'b1;
    if (probe) hold = 1'b1;
    t_acc = cyc;
    @(negedge clk);
    if (probe) begin
      // R10: a second command while busy must be ignored
      cmd_op = 2'd0; cmd_list = 8'hFF; cmd_base = 32'h0;
      chk(cmd_ready == 1'b0, "R10", "cmd_ready while busy", 32'(cmd_ready), 32'h0);
      @(negedge clk);
      chk(mem_req && mem_addr == e_addr[0], "R11", "stalled request held", mem_addr, e_addr[0]);
      hold = 1'b0;
    end
    cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    chk(got_k == n, cur_tag, "transfer count", 32'(got_k), 32'(n));
    chk(got_k == int'(v.cnt), cur_tag, "table count", 32'(got_k), 32'(v.cnt));
    chk(wb_value == v.wb, (v.op[1] ? "R5" : "R3"), "wb_value", wb_value, v.wb);
    chk(wb_value == x_wb, (v.op[1] ? "R5" : "R3"), "wb_value model", wb_value, x_wb);
    chk(wb_valid == exp_wv, "R3", "wb_valid", 32'(wb_valid), 32'(exp_wv));
    chk(wb_sp == exp_sp, "R5", "wb_sp", 32'(wb_sp), 32'(exp_sp));
    if (!v.op[1]) chk(wb_rn == v.rn, "R3", "wb_rn", 32'(wb_rn), 32'(v.rn));
    if (n > 0) chk(cyc == last_hs + 1, "R9", "done timing", cyc, last_hs + 1);
    else       chk(cyc == t_acc + 1, "R8", "empty done timing", cyc, t_acc + 1);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done width", 32'(done), 32'h0);
    for (int i = 0; i < 8; i++)
      chk(rf_m[i] == rf_exp[i], cur_tag, "register contents", rf_m[i], rf_exp[i]);
    if (v.op == 2'd3 && v.xt)
      chk(pc_seen && pc_got == exp_pc, "R6", "pc load", pc_got, exp_pc);
    else
      chk(!pc_seen, "R6", "unexpected pc load", 32'(pc_seen), 32'h0);
    if (probe) begin
      repeat (3) @(negedge clk);
      chk(got_k == n && !mem_req, "R10", "ignored command ran", 32'(got_k), 32'(n));
    end
  endtask

  initial begin
    rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_list = '0; cmd_rn = '0;
    cmd_extra = 1'b0; cmd_base = '0; cmd_lr = '0; mem_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cmd_ready == 1'b1, "R1", "cmd_ready", 32'(cmd_ready), 32'h1);
    chk(!mem_req && !done && !rf_we && !pc_we && !wb_valid, "R1", "idle outputs",
        {27'h0, mem_req, done, rf_we, pc_we, wb_valid}, 32'h0);
    // table walk; vector 3 also covers R7 (extra flag on a block store)
    for (int k = 0; k < NV; k++) begin
      stall = (k % 2 == 1);
      run_cmd(VEC[k], 1'b0);
    end
    // R10 / R11: busy probe with a held memory port
    stall = 1'b0;
    run_cmd('{2'd1, 8'h03, 3'd4, 1'b0, 32'h20, 4'd2, 32'h28}, 1'b1);
    // R7: extra flag on a block load changes nothing
    run_cmd('{2'd0, 8'h30, 3'd0, 1'b1, 32'h70, 4'd2, 32'h78}, 1'b0);
    // R8: empty block store
    run_cmd('{2'd1, 8'h00, 3'd6, 1'b0, 32'h90, 4'd0, 32'h90}, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule